// File: doc/BRIEF.md
# Load/Store Lane Aligner

This block sits between a 32-bit, word-wide memory data path and a processor core that addresses bytes. On the read side it receives the whole memory word, the two low address bits and the access size. It moves the addressed byte or halfword down into the least significant lanes, which lets the core's own sign or zero extension operate on bit 0 upward without changes. Byte lanes are numbered little-endian: lane 0 holds bits 7:0 and lane 3 holds bits 31:24. The aligner never sign-extends. Every bit above the selected portion is driven to zero.

On the write side it takes the core's store data. It copies a byte into all four lanes, or a halfword into both halves. It then produces an active-high byte-enable mask so that memory writes only the addressed lanes. A halfword access at an odd address is flagged as misaligned. For such an access the load data passes through unchanged and no byte is enabled for writing.

The `REG_OUT` parameter selects how the outputs are driven. When it is set (the default), all outputs come from registers with one cycle of latency and an asynchronous active-low reset. When it is clear, the unit is purely combinational.

Top module: `lane_aligner`

## Requirements
- R1: With size code 2'b10 (word), `ld_data_o` equals `mem_word_i` for any `addr_lo_i`.
- R2: With size code 2'b01 (halfword) and offset 2'b00, `ld_data_o` is `{16'h0, mem_word_i[15:0]}`.
- R3: With size code 2'b01 and offset 2'b10, `ld_data_o` is `{16'h0, mem_word_i[31:16]}`.
- R4: With size code 2'b00 (byte), `ld_data_o` is `{24'h0, lane}`. The lane is bits 7:0, 15:8, 23:16 or 31:24 for offset 0, 1, 2 or 3.
- R5: A halfword access with `addr_lo_i[0]`=1 raises `misalign_o`. `ld_data_o` then equals `mem_word_i` and `st_be_o` is 4'b0000. `misalign_o` is 0 for every other access.
- R6: For a byte access, `st_data_o` is `st_word_i[7:0]` repeated in all four lanes. `st_be_o` has only bit `addr_lo_i` set.
- R7: For a halfword access, `st_data_o` is `st_word_i[15:0]` in both halves. An aligned access gives `st_be_o` = 4'b0011 at offset 00 and 4'b1100 at offset 10.
- R8: For a word access, `st_data_o` equals `st_word_i` and `st_be_o` is 4'b1111.
- R9: Size code 2'b11 behaves exactly like a word access on every output.
- R10: With `REG_OUT`=1, every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_word_i | input | 32 | Word read from memory |
| addr_lo_i | input | 2 | Byte address bits 1:0 |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| st_word_i | input | 32 | Store data from the core, value in low lanes |
| ld_data_o | output | 32 | Load data shifted to the low lanes, zero-filled above |
| st_data_o | output | 32 | Store data with lanes replicated |
| st_be_o | output | 4 | Active-high byte enables, bit n for lane n |
| misalign_o | output | 1 | Halfword access at an odd address |

## Verification
The hardest condition to reach is a misaligned halfword. There the load path must fall back to plain pass-through, and the enables must drop to zero, even though the store data is still replicated. The stimulus table drives both odd offsets with a halfword size on a word whose lanes all differ, so that any shifted or partly masked result is visible. The bench also checks the one-cycle latency. It changes the inputs and samples before the next edge, expecting the old result, then samples again after the edge. Reset is asserted in the middle of the run to show that all outputs clear.

// File: rtl/lane_aligner.sv
module lane_aligner #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] mem_word_i,
  input  logic [1:0]  addr_lo_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] st_word_i,
  output logic [31:0] ld_data_o,
  output logic [31:0] st_data_o,
  output logic [3:0]  st_be_o,
  output logic        misalign_o
);

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  logic        is_byte, is_half, bad_half;
  logic [7:0]  sel_byte;
  logic [31:0] ld_c, st_c;
  logic [3:0]  be_c;

  assign is_byte  = (size_i == SZ_BYTE);
  assign is_half  = (size_i == SZ_HALF);
  assign bad_half = is_half & addr_lo_i[0];

  always_comb begin
    case (addr_lo_i)
      2'd0:    sel_byte = mem_word_i[7:0];
      2'd1:    sel_byte = mem_word_i[15:8];
      2'd2:    sel_byte = mem_word_i[23:16];
      default: sel_byte = mem_word_i[31:24];
    endcase
  end

  always_comb begin
    if (is_byte)
      ld_c = {24'h0, sel_byte};
    else if (is_half && !bad_half)
      ld_c = addr_lo_i[1] ? {16'h0, mem_word_i[31:16]} : {16'h0, mem_word_i[15:0]};
    else
      ld_c = mem_word_i;
  end

  always_comb begin
    if (is_byte) begin
      st_c = {4{st_word_i[7:0]}};
      be_c = 4'b0001 << addr_lo_i;
    end else if (is_half) begin
      st_c = {2{st_word_i[15:0]}};
      be_c = bad_half ? 4'b0000 : (addr_lo_i[1] ? 4'b1100 : 4'b0011);
    end else begin
      st_c = st_word_i;
      be_c = 4'b1111;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ld_data_o  <= '0;
          st_data_o  <= '0;
          st_be_o    <= '0;
          misalign_o <= 1'b0;
        end else begin
          ld_data_o  <= ld_c;
          st_data_o  <= st_c;
          st_be_o    <= be_c;
          misalign_o <= bad_half;
        end
      end
    end else begin : g_comb
      assign ld_data_o  = ld_c;
      assign st_data_o  = st_c;
      assign st_be_o    = be_c;
      assign misalign_o = bad_half;
    end
  endgenerate

endmodule

// File: rtl/lane_aligner_chk.sv
module lane_aligner_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] mem_word_i,
  input logic [1:0]  addr_lo_i,
  input logic [1:0]  size_i,
  input logic [31:0] st_word_i,
  input logic [31:0] ld_data_o,
  input logic [31:0] st_data_o,
  input logic [3:0]  st_be_o,
  input logic        misalign_o
);

  logic        seen_q;
  logic [31:0] w_q, s_q;
  logic [1:0]  a_q, z_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      w_q <= '0; s_q <= '0; a_q <= '0; z_q <= '0;
    end else begin
      seen_q <= 1'b1;
      w_q <= mem_word_i; s_q <= st_word_i; a_q <= addr_lo_i; z_q <= size_i;
    end
  end

  logic        h_ok;
  logic [31:0] h_w, h_s;
  logic [1:0]  h_a, h_z;
  assign h_ok = REG_OUT ? seen_q : 1'b1;
  assign h_w  = REG_OUT ? w_q : mem_word_i;
  assign h_s  = REG_OUT ? s_q : st_word_i;
  assign h_a  = REG_OUT ? a_q : addr_lo_i;
  assign h_z  = REG_OUT ? z_q : size_i;

  AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    h_ok && h_z[1] |-> ld_data_o == h_w && st_data_o == h_s && st_be_o == 4'hF && !misalign_o) // R1
    else $error("word pass");
  AST_HALF_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    h_ok && h_z == 2'b01 && !h_a[0] |-> ld_data_o[31:16] == 16'h0 && $countones(st_be_o) == 2) // R2
    else $error("half fill");
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    h_ok && h_z == 2'b00 |-> ld_data_o[31:8] == 24'h0 && $countones(st_be_o) == 1
      && st_data_o[31:24] == h_s[7:0]) // R4
    else $error("byte lane");
  AST_MISALIGN_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |-> st_be_o == 4'h0 && ld_data_o == h_w) // R5
    else $error("misalign");
  AST_HALF_REPL: assert property (@(posedge clk) disable iff (!rst_n)
    h_ok && h_z == 2'b01 |-> st_data_o[31:16] == st_data_o[15:0]) // R7
    else $error("half repl");

  generate
    if (REG_OUT) begin : g_rst
      AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> ld_data_o == '0 && st_be_o == '0 && !misalign_o) // R10
        else $error("reset clear");
    end
  endgenerate

endmodule

bind lane_aligner lane_aligner_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/test_lane_aligner.sv
`timescale 1ns/1ps
module test_lane_aligner;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_word_i = '0;
  logic [1:0]  addr_lo_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] st_word_i = '0;
  logic [31:0] ld_data_o, st_data_o;
  logic [3:0]  st_be_o;
  logic        misalign_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lane_aligner #(.REG_OUT(1'b1)) i_lane_aligner (.*);

  // {size, off, mem, st, exp_ld, exp_st, exp_be, exp_mis}
  localparam int NV = 12;
  localparam logic [136:0] VEC [NV] = '{
    {2'b10, 2'd0, 32'hA1B2C3D4, 32'h11223344, 32'hA1B2C3D4, 32'h11223344, 4'hF, 1'b0}, // R1 R8
    {2'b01, 2'd0, 32'hA1B2C3D4, 32'h11223344, 32'h0000C3D4, 32'h33443344, 4'h3, 1'b0}, // R2 R7
    {2'b01, 2'd2, 32'hA1B2C3D4, 32'h11223344, 32'h0000A1B2, 32'h33443344, 4'hC, 1'b0}, // R3 R7
    {2'b01, 2'd1, 32'hA1B2C3D4, 32'h11223344, 32'hA1B2C3D4, 32'h33443344, 4'h0, 1'b1}, // R5
    {2'b01, 2'd3, 32'hA1B2C3D4, 32'h11223344, 32'hA1B2C3D4, 32'h33443344, 4'h0, 1'b1}, // R5
    {2'b00, 2'd0, 32'hA1B2C3D4, 32'h11223344, 32'h000000D4, 32'h44444444, 4'h1, 1'b0}, // R4 R6
    {2'b00, 2'd1, 32'hA1B2C3D4, 32'h11223344, 32'h000000C3, 32'h44444444, 4'h2, 1'b0}, // R4 R6
    {2'b00, 2'd2, 32'hA1B2C3D4, 32'h11223344, 32'h000000B2, 32'h44444444, 4'h4, 1'b0}, // R4 R6
    {2'b00, 2'd3, 32'hA1B2C3D4, 32'h11223344, 32'h000000A1, 32'h44444444, 4'h8, 1'b0}, // R4 R6
    {2'b11, 2'd1, 32'hA1B2C3D4, 32'h11223344, 32'hA1B2C3D4, 32'h11223344, 4'hF, 1'b0}, // R9
    {2'b10, 2'd2, 32'h80FF017E, 32'hDEADBEEF, 32'h80FF017E, 32'hDEADBEEF, 4'hF, 1'b0}, // R1 R8
    {2'b00, 2'd3, 32'hFF000000, 32'h000000AB, 32'h000000FF, 32'hABABABAB, 4'h8, 1'b0}  // R4 R6
  };

  task automatic check(string req, logic [31:0] el, logic [31:0] es, logic [3:0] eb, logic em);
    n_run++;
    if (ld_data_o !== el || st_data_o !== es || st_be_o !== eb || misalign_o !== em) begin
      n_fail++;
      $display("FAIL %s: got ld=%h st=%h be=%b mis=%b, expected ld=%h st=%h be=%b mis=%b",
               req, ld_data_o, st_data_o, st_be_o, misalign_o, el, es, eb, em);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    mem_word_i = 32'hFFFFFFFF; size_i = 2'b01; addr_lo_i = 2'd1; st_word_i = 32'hFFFFFFFF;
    @(negedge clk);
    check("R10 reset", '0, '0, 4'h0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [136:0] v;
      string tag;
      v = VEC[i];
      size_i = v[136:135]; addr_lo_i = v[134:133];
      mem_word_i = v[132:101]; st_word_i = v[100:69];
      @(negedge clk);
      tag = $sformatf("vec%0d (R1..R9 table)", i);
      check(tag, v[68:37], v[36:5], v[4:1], v[0]);
    end

    // R10 latency: result holds until next edge
    size_i = 2'b00; addr_lo_i = 2'd2; mem_word_i = 32'h00550000; st_word_i = 32'h0000005A;
    #1;
    check("R10 hold", 32'h000000FF, 32'hABABABAB, 4'h8, 1'b0);
    @(negedge clk);
    check("R10 update R4", 32'h00000055, 32'h5A5A5A5A, 4'h4, 1'b0);

    // R5 odd halfword with clear misalign afterwards
    size_i = 2'b01; addr_lo_i = 2'd3; mem_word_i = 32'h12345678; st_word_i = 32'h0000BEEF;
    @(negedge clk);
    check("R5 odd half", 32'h12345678, 32'hBEEFBEEF, 4'h0, 1'b1);
    addr_lo_i = 2'd2;
    @(negedge clk);
    check("R3 after R5", 32'h00001234, 32'hBEEFBEEF, 4'hC, 1'b0);

    // R9 reserved size on odd offset must not flag
    size_i = 2'b11; addr_lo_i = 2'd3;
    @(negedge clk);
    check("R9 reserved", 32'h12345678, 32'h0000BEEF, 4'hF, 1'b0);

    // R10 mid-run reset
    rst_n = 1'b0;
    #1;
    check("R10 async reset", '0, '0, 4'h0, 1'b0);
    @(negedge clk);
    check("R10 reset held", '0, '0, 4'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset R8", 32'h12345678, 32'h0000BEEF, 4'hF, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule